// File: doc/BRIEF.md
# Batch-Ranked Bank Request Scheduler

This block chooses which pending memory request each bank serves next, in a controller that several hardware threads share. Every request carries a thread number, a bank number and a row. Requests wait in per-bank queues that keep them in arrival order. The scheduler gathers the pending work into batches, and a batch must drain before any request that arrived after it was formed. This bounds how long any thread can wait, so no thread is starved.

When a batch is formed, the scheduler ranks the threads. A thread with little marked work in its busiest bank ranks highest. Its requests to different banks therefore tend to be granted in the same cycles, and the thread waits for one overlapped access time instead of a chain of them.

Each bank gets at most one grant per cycle. The grant is taken when the bank's ready input is high. A separate output pulses in the cycle the final request of the batch is taken. DRAM command timing is handled downstream of the grant handshake.

Top module: `batch_rank_sched`

## Requirements
- R1: A new batch is formed in any cycle in which the queues hold at least one request but no marked request. In that cycle no grant is raised. On the next clock edge, the scheduler marks the oldest requests of each thread in each bank, up to `mark_cap` per thread per bank. A `mark_cap` of 0 counts as 1. A request accepted in the forming cycle stays unmarked.
- R2: Within a bank, a marked request is always granted before an unmarked one.
- R3: Among requests with the same marked state, a request whose row equals the bank's open row is preferred. The open row is the row of the last request issued to that bank. After reset no bank has an open row.
- R4: When a batch is formed, each thread gets a rank. Thread A ranks above thread B in three steps. First, A ranks higher if its largest per-bank count of newly marked requests is smaller. If those are equal, A ranks higher if its total newly marked count is smaller. If both are equal, the lower thread number ranks higher. Among requests that tie on R2 and R3, the higher-ranked thread is granted first. Ranks hold until the next batch is formed.
- R5: Requests that tie on R2, R3 and R4 are granted oldest first.
- R6: Each bank raises at most one grant. The grant presents the chosen request's thread and row. The request issues when `bank_ready` for that bank is high, and it then leaves the queue.
- R7: `batch_done` is high in exactly the cycle in which the last marked request still queued issues.
- R8: `req_ready` is low when the addressed bank's queue holds `DEPTH` requests, and high otherwise. An accepted request joins its bank's queue as the youngest entry.
- R9: After reset, all queues are empty, no grant is raised, `batch_done` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mark_cap | input | $clog2(DEPTH+1) | Maximum marked requests per thread per bank |
| req_valid | input | 1 | New request present |
| req_ready | output | 1 | Addressed bank queue can accept |
| req_thread | input | $clog2(NT) | Thread of new request |
| req_bank | input | $clog2(NB) | Bank of new request |
| req_row | input | ROWW | Row of new request |
| bank_ready | input | NB | Per-bank: grant can be taken this cycle |
| gnt_valid | output | NB | Per-bank grant present |
| gnt_thread | output | NB*$clog2(NT) | Per-bank granted thread, bank b at slice b |
| gnt_row | output | NB*ROWW | Per-bank granted row, bank b at slice b |
| batch_done | output | 1 | Last request of the batch issues this cycle |

## Verification
The stimulus uses one heavy thread that keeps hitting a single row of one bank, against light threads spread over all banks. This checks that ranking puts the light threads ahead of the hog. A scheduler that ranks by total load instead of the busiest bank, or that drops the thread-number tie-break, would grant a different thread in the cycle after a batch forms.

Requests are injected while a batch is still draining. An unmarked request granted ahead of a marked one in the same bank would show up as a wrong thread or row on that bank's grant.

Arrivals and removals are made to collide in the same bank, with the queue full. This exposes a write-slot error after compaction, or a ready signal computed from the updated count.

Several cap values, including 0, exercise the marking limit. The bench also checks the idle forming cycle and the `batch_done` pulse at the edge of each batch.

// File: rtl/batch_rank_sched.sv
module batch_rank_sched #(
  parameter int NT = 4,
  parameter int NB = 4,
  parameter int DEPTH = 4,
  parameter int ROWW = 4,
  localparam int TW = $clog2(NT),
  localparam int BW = $clog2(NB),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH),
  localparam int SW = $clog2(NB * DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CW-1:0]      mark_cap,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [TW-1:0]      req_thread,
  input  logic [BW-1:0]      req_bank,
  input  logic [ROWW-1:0]    req_row,
  input  logic [NB-1:0]      bank_ready,
  output logic [NB-1:0]      gnt_valid,
  output logic [NB*TW-1:0]   gnt_thread,
  output logic [NB*ROWW-1:0] gnt_row,
  output logic               batch_done
);

  logic [TW-1:0]   q_thr  [NB][DEPTH];
  logic [ROWW-1:0] q_row  [NB][DEPTH];
  logic [DEPTH-1:0] q_mark [NB];
  logic [CW-1:0]   cnt    [NB];
  logic [ROWW-1:0] open_row [NB];
  logic [NB-1:0]   open_v;
  logic [TW-1:0]   rank [NT];

  logic [DEPTH-1:0] mk_new [NB];
  logic [CW-1:0]   pcnt [NT][NB];
  logic [CW-1:0]   mx   [NT];
  logic [SW-1:0]   tot  [NT];
  logic [TW-1:0]   nrank [NT];
  logic [SW-1:0]   mtot, mdone;
  logic [IW-1:0]   sel [NB];
  logic [NB-1:0]   found, issue, bank_has_mark;
  logic [TW+1:0]   key, bkey;
  logic            form, any_req, accept;

  wire [CW-1:0] cap_eff = (mark_cap == '0) ? CW'(1) : mark_cap;

  always_comb begin
    mtot = '0;
    any_req = 1'b0;
    for (int t = 0; t < NT; t++)
      for (int b = 0; b < NB; b++) pcnt[t][b] = '0;
    for (int b = 0; b < NB; b++) begin
      mk_new[b] = '0;
      bank_has_mark[b] = |q_mark[b];
      any_req = any_req | (cnt[b] != '0);
      for (int i = 0; i < DEPTH; i++) begin
        if (CW'(i) < cnt[b]) begin
          mtot = mtot + SW'(q_mark[b][i]);
          if (pcnt[q_thr[b][i]][b] < cap_eff) begin
            mk_new[b][i] = 1'b1;
            pcnt[q_thr[b][i]][b] = pcnt[q_thr[b][i]][b] + CW'(1);
          end
        end
      end
    end
    for (int t = 0; t < NT; t++) begin
      mx[t] = '0;
      tot[t] = '0;
      for (int b = 0; b < NB; b++) begin
        if (pcnt[t][b] > mx[t]) mx[t] = pcnt[t][b];
        tot[t] = tot[t] + SW'(pcnt[t][b]);
      end
    end
    for (int t = 0; t < NT; t++) begin
      nrank[t] = '0;
      for (int u = 0; u < NT; u++)
        if (u != t && ((mx[u] < mx[t]) || (mx[u] == mx[t] && tot[u] < tot[t]) ||
                       (mx[u] == mx[t] && tot[u] == tot[t] && u < t)))
          nrank[t] = nrank[t] + TW'(1);
    end
  end

  always_comb begin
    key = '0;
    bkey = '0;
    for (int b = 0; b < NB; b++) begin
      found[b] = 1'b0;
      sel[b] = '0;
      bkey = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (CW'(i) < cnt[b]) begin
          key = {q_mark[b][i], open_v[b] && (q_row[b][i] == open_row[b]), ~rank[q_thr[b][i]]};
          if (!found[b] || key > bkey) begin
            found[b] = 1'b1;
            sel[b] = IW'(i);
            bkey = key;
          end
        end
      end
    end
  end

  assign form      = (mtot == '0) && any_req;
  assign gnt_valid = found & {NB{!form}};
  assign issue     = gnt_valid & bank_ready;
  assign req_ready = cnt[req_bank] < CW'(DEPTH);
  assign accept    = req_valid && req_ready;

  always_comb begin
    mdone = '0;
    for (int b = 0; b < NB; b++) mdone = mdone + SW'(issue[b] & q_mark[b][sel[b]]);
  end
  assign batch_done = (mtot != '0) && (mdone == mtot);

  for (genvar b = 0; b < NB; b++) begin : g_out
    assign gnt_thread[b*TW +: TW]     = q_thr[b][sel[b]];
    assign gnt_row[b*ROWW +: ROWW]    = q_row[b][sel[b]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_v <= '0;
      for (int t = 0; t < NT; t++) rank[t] <= '0;
      for (int b = 0; b < NB; b++) begin
        cnt[b] <= '0;
        q_mark[b] <= '0;
        open_row[b] <= '0;
        for (int i = 0; i < DEPTH; i++) begin
          q_thr[b][i] <= '0;
          q_row[b][i] <= '0;
        end
      end
    end else begin
      if (form) begin
        for (int b = 0; b < NB; b++) q_mark[b] <= mk_new[b];
        for (int t = 0; t < NT; t++) rank[t] <= nrank[t];
      end
      for (int b = 0; b < NB; b++) begin
        if (issue[b]) begin
          open_row[b] <= q_row[b][sel[b]];
          open_v[b] <= 1'b1;
          for (int i = 0; i < DEPTH - 1; i++) begin
            if (IW'(i) >= sel[b]) begin
              q_thr[b][i]  <= q_thr[b][i+1];
              q_row[b][i]  <= q_row[b][i+1];
              q_mark[b][i] <= q_mark[b][i+1];
            end
          end
          q_mark[b][DEPTH-1] <= 1'b0;
        end
        if (accept && req_bank == BW'(b)) begin
          q_thr[b][IW'(cnt[b] - CW'(issue[b]))]  <= req_thread;
          q_row[b][IW'(cnt[b] - CW'(issue[b]))]  <= req_row;
          q_mark[b][IW'(cnt[b] - CW'(issue[b]))] <= 1'b0;
        end
        cnt[b] <= cnt[b] + CW'(accept && req_bank == BW'(b)) - CW'(issue[b]);
      end
    end
  end

  a_r1_batch_marks: assert property (@(posedge clk) disable iff (!rst_n)
    form |=> (mtot != '0));
  a_r7_done_empties: assert property (@(posedge clk) disable iff (!rst_n)
    batch_done |=> !(|bank_has_mark));

  for (genvar b = 0; b < NB; b++) begin : g_chk
    a_r2_marked_first: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid[b] && bank_has_mark[b]) |-> q_mark[b][sel[b]]);
    a_r3_open_row: assert property (@(posedge clk) disable iff (!rst_n)
      issue[b] |=> (open_v[b] && open_row[b] == $past(gnt_row[b*ROWW +: ROWW])));
    a_r8_append: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_bank == BW'(b) && !issue[b]) |=> (cnt[b] == $past(cnt[b]) + CW'(1)));
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[b] <= CW'(DEPTH));
  end

endmodule

// File: tb/batch_rank_sched_tb_top.sv
module batch_rank_sched_tb_top;
  localparam int NT = 4, NB = 4, DEPTH = 4, ROWW = 4;
  localparam int TW = $clog2(NT), BW = $clog2(NB), CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] mark_cap = '0;
  logic req_valid = 1'b0, req_ready;
  logic [TW-1:0] req_thread = '0;
  logic [BW-1:0] req_bank = '0;
  logic [ROWW-1:0] req_row = '0;
  logic [NB-1:0] bank_ready = '0, gnt_valid;
  logic [NB*TW-1:0] gnt_thread;
  logic [NB*ROWW-1:0] gnt_row;
  logic batch_done;

  always #10 clk = ~clk;

  batch_rank_sched #(.NT(NT), .NB(NB), .DEPTH(DEPTH), .ROWW(ROWW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mark_cap(mark_cap), .req_valid(req_valid),
    .req_ready(req_ready), .req_thread(req_thread), .req_bank(req_bank),
    .req_row(req_row), .bank_ready(bank_ready), .gnt_valid(gnt_valid),
    .gnt_thread(gnt_thread), .gnt_row(gnt_row), .batch_done(batch_done));

  int checks = 0, fails = 0;
  int qt [NB][$];
  int qr [NB][$];
  int qm [NB][$];
  int orow [NB];
  int ov [NB];
  int rk [NT];
  int esel [NB];
  int evalid [NB];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int capv();
    return (mark_cap == 0) ? 1 : int'(mark_cap);
  endfunction

  task automatic model_form();
    int pc [NT][NB];
    int mxv [NT];
    int tv [NT];
    for (int t = 0; t < NT; t++) begin
      mxv[t] = 0; tv[t] = 0;
      for (int b = 0; b < NB; b++) pc[t][b] = 0;
    end
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < qt[b].size(); i++)
        if (pc[qt[b][i]][b] < capv()) begin
          qm[b][i] = 1;
          pc[qt[b][i]][b]++;
        end
    for (int t = 0; t < NT; t++)
      for (int b = 0; b < NB; b++) begin
        if (pc[t][b] > mxv[t]) mxv[t] = pc[t][b];
        tv[t] += pc[t][b];
      end
    for (int t = 0; t < NT; t++) begin
      rk[t] = 0;
      for (int u = 0; u < NT; u++)
        if (u != t && (mxv[u] < mxv[t] || (mxv[u] == mxv[t] && tv[u] < tv[t]) ||
                       (mxv[u] == mxv[t] && tv[u] == tv[t] && u < t)))
          rk[t]++;
    end
  endtask

  task automatic step();
    int mtot, anyq, form, mdone, edone, ok;
    int bm, bh, br, m, h, r;
    mtot = 0; anyq = 0; mdone = 0;
    for (int b = 0; b < NB; b++) begin
      if (qt[b].size() != 0) anyq = 1;
      for (int i = 0; i < qm[b].size(); i++) mtot += qm[b][i];
    end
    form = (mtot == 0 && anyq != 0) ? 1 : 0;
    for (int b = 0; b < NB; b++) begin
      esel[b] = -1; bm = 0; bh = 0; br = 0;
      for (int i = 0; i < qt[b].size(); i++) begin
        m = qm[b][i];
        h = (ov[b] != 0 && qr[b][i] == orow[b]) ? 1 : 0;
        r = rk[qt[b][i]];
        if (esel[b] < 0 || m > bm || (m == bm && h > bh) || (m == bm && h == bh && r < br)) begin
          esel[b] = i; bm = m; bh = h; br = r;
        end
      end
      evalid[b] = (esel[b] >= 0 && form == 0) ? 1 : 0;
      chk(gnt_valid[b] == evalid[b][0], "R1 R6 grant valid", int'(gnt_valid[b]), evalid[b]);
      if (evalid[b] != 0) begin
        chk(int'(gnt_thread[b*TW +: TW]) == qt[b][esel[b]], "R2 R3 R4 R5 grant thread",
            int'(gnt_thread[b*TW +: TW]), qt[b][esel[b]]);
        chk(int'(gnt_row[b*ROWW +: ROWW]) == qr[b][esel[b]], "R2 R3 R5 grant row",
            int'(gnt_row[b*ROWW +: ROWW]), qr[b][esel[b]]);
        if (bank_ready[b]) mdone += qm[b][esel[b]];
      end
    end
    edone = (mtot != 0 && mdone == mtot) ? 1 : 0;
    chk(batch_done == edone[0], "R7 batch done", int'(batch_done), edone);
    ok = (qt[req_bank].size() < DEPTH) ? 1 : 0;
    chk(req_ready == ok[0], "R8 ready", int'(req_ready), ok);
    @(posedge clk);
    if (form != 0) model_form();
    for (int b = 0; b < NB; b++)
      if (evalid[b] != 0 && bank_ready[b]) begin
        orow[b] = qr[b][esel[b]]; ov[b] = 1;
        qt[b].delete(esel[b]); qr[b].delete(esel[b]); qm[b].delete(esel[b]);
      end
    if (req_valid && ok != 0) begin
      qt[req_bank].push_back(int'(req_thread));
      qr[req_bank].push_back(int'(req_row));
      qm[req_bank].push_back(0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin orow[b] = 0; ov[b] = 0; end
    for (int t = 0; t < NT; t++) rk[t] = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(gnt_valid == '0, "R9 reset grant", int'(gnt_valid), 0);
    chk(batch_done == 1'b0, "R9 reset done", int'(batch_done), 0);
    chk(req_ready == 1'b1, "R9 reset ready", int'(req_ready), 1);
    rst_n = 1'b1;
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      case ((c / 1000) % 6)
        0: mark_cap = CW'(1);
        1: mark_cap = CW'(2);
        2: mark_cap = CW'(0);
        3: mark_cap = CW'(3);
        4: mark_cap = CW'(4);
        default: mark_cap = CW'(2);
      endcase
      req_valid = ($urandom_range(0, 9) < 7);
      if ($urandom_range(0, 1) == 0) begin
        req_thread = '0; req_bank = '0; req_row = ROWW'(1);
      end else begin
        req_thread = TW'($urandom_range(0, NT - 1));
        req_bank = BW'($urandom_range(0, NB - 1));
        req_row = ROWW'($urandom_range(0, 3));
      end
      for (int b = 0; b < NB; b++)
        bank_ready[b] = ((c % 200) < 40) ? 1'b0 : ($urandom_range(0, 2) != 0);
      #1;
      step();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule